// File: doc/BRIEF.md
# Prefix-Tree Magnitude Comparator

This block compares two unsigned operands of a parameterised width, a multiple of four bits. It needs no clock. Every bit position gets a two-bit code, held on two buses. The greater bus marks a position where the first operand holds 1 and the second holds 0. The lesser bus marks the opposite case. Only the most significant position where the operands differ may carry a code. Every position below it is masked to zero, so each bus is either all zero or has exactly one bit set.

The masking works in two steps. First, a per-position difference flag is NOR-combined inside each four-bit group. Second, the group results are combined in cumulative order from the most significant group down, so a group only lets lower positions through while everything above it agrees. Each output position is a two-input multiplexer. It selects either the operand bit pair or the constant zero pair. The decision stage OR-reduces each bus, first per group and then across groups, into two summary bits. These are decoded into greater, less and equal flags and an error flag.

Top module: `prefix_cmp`

## Requirements
- R1: When op_a > op_b, greater_bus has exactly the single bit at the most significant position where the operands differ.
- R2: When op_a < op_b, lesser_bus has exactly the single bit at the most significant position where the operands differ.
- R3: Each bus has at most one bit set. Every position below the highest differing position is 0 on both buses, whatever the lower operand bits are.
- R4: When op_a == op_b, both buses are all zero. A position where both operands hold 1 contributes nothing to either bus.
- R5: sum_g equals the OR of all greater_bus bits, and sum_l equals the OR of all lesser_bus bits.
- R6: The summary pair {sum_g, sum_l} decodes as follows: 10 gives is_gt = 1, 01 gives is_lt = 1, 00 gives is_eq = 1. Exactly one of the three flags is high for any input.
- R7: sum_g and sum_l are never both 1, and bad_code stays 0.
- R8: With WIDTH = 8, op_a = 0x5D and op_b = 0x69 give greater_bus = 0x00, lesser_bus = 0x20 and {sum_g, sum_l} = 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| greater_bus | output | WIDTH | Masked bus, bit set where op_a holds 1 over op_b's 0 at the deciding position |
| lesser_bus | output | WIDTH | Masked bus, bit set where op_b holds 1 over op_a's 0 at the deciding position |
| sum_g | output | 1 | OR of greater_bus |
| sum_l | output | 1 | OR of lesser_bus |
| is_gt | output | 1 | op_a is greater than op_b |
| is_lt | output | 1 | op_a is less than op_b |
| is_eq | output | 1 | Operands are equal |
| bad_code | output | 1 | Both summary bits set (never expected) |

## Verification
The block has no state, so a fault in the masking path shows up at once, in the same evaluation, on the buses. Suppose a group's quiet flag or an in-group select is wrong. Then a second bit appears on a bus, the deciding bit goes missing, or a lower position leaks through. The wrong bus value then carries into the summary bits and the decoded flags. The bench sweeps every 8-bit operand pair, so every deciding position sits behind every lower-bit pattern. The 32-bit and 64-bit instances receive patterns that are random, equal, one bit apart, or differ only in the low half, so that faults in the cumulative group chain also show.

// File: rtl/prefix_cmp.sv
module prefix_cmp #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] greater_bus,
  output logic [WIDTH-1:0] lesser_bus,
  output logic             sum_g,
  output logic             sum_l,
  output logic             is_gt,
  output logic             is_lt,
  output logic             is_eq,
  output logic             bad_code
);
  localparam int GROUPS = WIDTH / 4;

  logic [WIDTH-1:0]  diff;
  logic [WIDTH-1:0]  sel;
  logic [GROUPS-1:0] grp_quiet;
  logic [GROUPS-1:0] upper_quiet;
  logic [GROUPS-1:0] grp_g;
  logic [GROUPS-1:0] grp_l;

  assign diff = op_a ^ op_b;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_quiet[g] = ~|diff[4*g +: 4];
    assign grp_g[g]     = |greater_bus[4*g +: 4];
    assign grp_l[g]     = |lesser_bus[4*g +: 4];
  end

  always_comb begin
    upper_quiet[GROUPS-1] = 1'b1;
    for (int g = GROUPS - 2; g >= 0; g--)
      upper_quiet[g] = upper_quiet[g+1] & grp_quiet[g+1];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_pos
    for (genvar j = 0; j < 4; j++) begin : g_bit
      localparam int K = 4 * g + j;
      logic in_grp_quiet;
      if (j == 3) begin : g_top
        assign in_grp_quiet = 1'b1;
      end else begin : g_low
        assign in_grp_quiet = ~|diff[4*g+3 : K+1];
      end
      assign sel[K]         = upper_quiet[g] & in_grp_quiet & diff[K];
      assign greater_bus[K] = sel[K] ? op_a[K] : 1'b0;
      assign lesser_bus[K]  = sel[K] ? op_b[K] : 1'b0;
    end
  end

  assign sum_g    = |grp_g;
  assign sum_l    = |grp_l;
  assign is_gt    = sum_g & ~sum_l;
  assign is_lt    = ~sum_g & sum_l;
  assign is_eq    = ~sum_g & ~sum_l;
  assign bad_code = sum_g & sum_l;

  always_comb begin
    // R3
    greater_onehot_chk: assert ($onehot0(greater_bus)) else $error("greater bus has several bits");
    // R3
    lesser_onehot_chk: assert ($onehot0(lesser_bus)) else $error("lesser bus has several bits");
    // R4
    equal_quiet_chk: assert (op_a != op_b || (greater_bus == '0 && lesser_bus == '0))
      else $error("equal operands left a code on a bus");
    // R7
    no_both_chk: assert (!(sum_g && sum_l)) else $error("both summary bits set");
    // R1
    gt_order_chk: assert (!is_gt || op_a > op_b) else $error("greater flag with op_a not greater");
    // R2
    lt_order_chk: assert (!is_lt || op_a < op_b) else $error("less flag with op_a not less");
  end
endmodule

// File: tb/test_prefix_cmp.sv
`timescale 1ns/1ps
module test_prefix_cmp;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [7:0]  a8,  b8;
  logic [31:0] a32, b32;
  logic [63:0] a64, b64;

  logic [7:0]  gb8,  lb8;
  logic [31:0] gb32, lb32;
  logic [63:0] gb64, lb64;
  logic sg8, sl8, gt8, lt8, eq8, bad8;
  logic sg32, sl32, gt32, lt32, eq32, bad32;
  logic sg64, sl64, gt64, lt64, eq64, bad64;

  prefix_cmp #(.WIDTH(8)) i_prefix_cmp (
    .op_a(a8), .op_b(b8), .greater_bus(gb8), .lesser_bus(lb8),
    .sum_g(sg8), .sum_l(sl8), .is_gt(gt8), .is_lt(lt8), .is_eq(eq8), .bad_code(bad8));
  prefix_cmp #(.WIDTH(32)) i_prefix_cmp_w32 (
    .op_a(a32), .op_b(b32), .greater_bus(gb32), .lesser_bus(lb32),
    .sum_g(sg32), .sum_l(sl32), .is_gt(gt32), .is_lt(lt32), .is_eq(eq32), .bad_code(bad32));
  prefix_cmp #(.WIDTH(64)) i_prefix_cmp_w64 (
    .op_a(a64), .op_b(b64), .greater_bus(gb64), .lesser_bus(lb64),
    .sum_g(sg64), .sum_l(sl64), .is_gt(gt64), .is_lt(lt64), .is_eq(eq64), .bad_code(bad64));

  function automatic int top_diff(logic [63:0] x);
    for (int k = 63; k >= 0; k--) if (x[k]) return k;
    return -1;
  endfunction

  task automatic expect64(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic judge(string tag, logic [63:0] a, logic [63:0] b, logic [63:0] gb, logic [63:0] lb,
                       logic sg, logic sl, logic gt, logic lt, logic eq, logic bad);
    int pos;
    logic [63:0] exp_g, exp_l;
    pos   = top_diff(a ^ b);
    exp_g = (a > b) ? (64'd1 << pos) : 64'd0;
    exp_l = (a < b) ? (64'd1 << pos) : 64'd0;
    expect64("R1", {tag, " greater_bus"}, gb, exp_g);
    expect64("R2", {tag, " lesser_bus"}, lb, exp_l);
    expect64("R3", {tag, " bus weight ok"}, 64'(($countones(gb) <= 1) && ($countones(lb) <= 1)), 64'd1);
    if (a == b) expect64("R4", {tag, " equal buses"}, gb | lb, 64'd0);
    expect64("R5", {tag, " sum bits"}, {62'd0, sg, sl}, {62'd0, |gb, |lb});
    expect64("R6", {tag, " flags gt/lt/eq"}, {61'd0, gt, lt, eq}, {61'd0, a > b, a < b, a == b});
    expect64("R7", {tag, " bad_code"}, {63'd0, bad}, 64'd0);
  endtask

  task automatic judge_all();
    judge("w8",  64'(a8),  64'(b8),  64'(gb8),  64'(lb8),  sg8,  sl8,  gt8,  lt8,  eq8,  bad8);
    judge("w32", 64'(a32), 64'(b32), 64'(gb32), 64'(lb32), sg32, sl32, gt32, lt32, eq32, bad32);
    judge("w64", a64, b64, gb64, lb64, sg64, sl64, gt64, lt64, eq64, bad64);
  endtask

  task automatic wide_pattern(int i);
    logic [63:0] r;
    r   = {$urandom, $urandom};
    a64 = {$urandom, $urandom};
    case (i % 4)
      0: b64 = r;
      1: b64 = a64;
      2: b64 = a64 ^ (64'd1 << ($urandom % 64));
      default: b64 = {a64[63:32], r[31:0]};
    endcase
    a32 = a64[31:0];
    b32 = (i % 4 == 3) ? {a64[31:16], r[15:0]} : b64[31:0];
  endtask

  initial begin
    #(8.0 * 190000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    a8 = 8'h00; b8 = 8'h00; a32 = '0; b32 = '0; a64 = '0; b64 = '0;
    @(negedge clk);
    // R4: initial all-zero operands give quiet buses and equal flag
    expect64("R4", "initial buses", 64'(gb8) | 64'(lb8), 64'd0);
    expect64("R6", "initial eq", {63'd0, eq8}, 64'd1);

    // R8: worked example
    @(posedge clk);
    a8 = 8'h5D; b8 = 8'h69;
    @(negedge clk);
    expect64("R8", "example lesser_bus", 64'(lb8), 64'h20);
    expect64("R8", "example greater_bus", 64'(gb8), 64'h00);
    expect64("R8", "example summary", {62'd0, sg8, sl8}, 64'b01);

    // R4: all-ones equal operands
    @(posedge clk);
    a8 = 8'hFF; b8 = 8'hFF; a64 = '1; b64 = '1; a32 = '1; b32 = '1;
    @(negedge clk);
    judge_all();

    // R1 R2 R3: top bits differ, lower bits adversarial
    @(posedge clk);
    a64 = 64'h8000_0000_0000_0000; b64 = 64'h7FFF_FFFF_FFFF_FFFF;
    a32 = 32'h0000_0001; b32 = 32'h0000_0000;
    @(negedge clk);
    judge_all();

    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      a8 = i[15:8];
      b8 = i[7:0];
      wide_pattern(i);
      @(negedge clk);
      judge_all();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule